// File: doc/BRIEF.md
# Register-Mapped Inter-Processor Mailbox Endpoint

This block is one end of a message channel between two processors. A single bus master sees a small 32-bit register window. Writing the transmit data register queues a word in an outbound FIFO. Reading the receive data register takes the oldest word from an inbound FIFO. The outbound FIFO drains through a valid/ready stream, and the inbound FIFO fills from one, so two endpoints wired back to back make a bidirectional mailbox.

Each direction has a programmable occupancy threshold. The outbound flag means "the queue has drained to the threshold or below". The inbound flag means "more words than the threshold are waiting". Misuse of the data registers is recorded in a sticky error register. That covers popping an empty inbound queue and pushing into a full outbound queue. Both FIFOs can be flushed through a control register. The threshold flags and the error event feed a status/enable/pending interrupt scheme that ends in one interrupt line.

Register reads have one cycle of latency: `reg_rdata` is loaded at the clock edge that samples `reg_rd_en` and holds until the next read. The register map, with byte offsets, is:

| Offset | Register | Access |
|--------|----------|--------|
| 0x00 | transmit data | write |
| 0x08 | receive data | read |
| 0x10 | status | read |
| 0x14 | error | read |
| 0x18 | transmit threshold | read/write |
| 0x1C | receive threshold | read/write |
| 0x20 | interrupt status | read, write 1 to clear |
| 0x24 | interrupt enable | read/write |
| 0x28 | interrupt pending | read |
| 0x2C | control | write |

Top module: `mbx_endpoint`

## Requirements
- R1: After reset:
  - status (0x10) reads 0x5;
  - error, both thresholds, interrupt status, enable and pending all read 0;
  - `irq` and `tx_valid` are low and `rx_ready` is high.
- R2: Words written to 0x00 leave on `tx_data` in write order. `tx_valid` is high exactly while the outbound FIFO holds a word. Status bit 1 is 1 when the outbound FIFO holds DEPTH words.
- R3: A stream word is accepted when `rx_valid` and `rx_ready` are both high. `rx_ready` is low while the inbound FIFO holds DEPTH words. Reading 0x08 returns the oldest word and removes it. Status bit 0 is 1 when the inbound FIFO is empty.
- R4: A write to 0x00 while the outbound FIFO is full is discarded and leaves the FIFO contents unchanged. It sets error bit 1.
- R5: A read of 0x08 while the inbound FIFO is empty returns 0 and leaves the FIFO unchanged. It sets error bit 0.
- R6: Error bits stay set until the error register (0x14) is read. That read returns the accumulated bits and clears them.
- R7: Status bit 2 is 1 exactly when the outbound occupancy is less than or equal to the transmit threshold (0x18).
- R8: Status bit 3 is 1 exactly when the inbound occupancy is strictly greater than the receive threshold (0x1C).
- R9: Both thresholds reset to 0. Writes keep only the low $clog2(DEPTH+1) bits, and reads return that value zero-extended.
- R10: Writing control (0x2C) with bit 0 set flushes the outbound FIFO. Writing it with bit 1 set flushes the inbound FIFO. The other FIFO is untouched, and control reads 0.
- R11: Interrupt status bits set on a 0-to-1 change of their source, and only after reset. The sources are bit 0 for the transmit threshold flag, bit 1 for the receive threshold flag and bit 2 for an error event. Set bits stay set until a 1 is written to that bit of 0x20.
- R12: Interrupt pending (0x28) equals interrupt status AND interrupt enable (0x24). `irq` is high exactly when any pending bit is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after the read strobe |
| tx_valid | output | 1 | Outbound stream word available |
| tx_ready | input | 1 | Outbound stream consumer ready |
| tx_data | output | 32 | Outbound stream word |
| rx_valid | input | 1 | Inbound stream word offered |
| rx_ready | output | 1 | Inbound FIFO can accept a word |
| rx_data | input | 32 | Inbound stream word |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted occupancy count or pointer shows at the ports within one register read: the threshold bits of the status word would disagree with the bench's own count. The next stream transfer or data read would also return a word out of order. A lost or spurious error capture appears on the very next read of the error register. A wrong edge detector or enable mask shows on the interrupt status read two cycles after the source changes, and on `irq` in the cycle after the enable write. Sweeping every threshold against every occupancy of a four-deep configuration exposes off-by-one comparisons at both ends.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;

  // register byte offsets
  localparam logic [ADDR_W-1:0] OFS_TXD  = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_RXD  = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_STAT = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_ERR  = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_TXTH = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_RXTH = 6'h1C;
  localparam logic [ADDR_W-1:0] OFS_ISR  = 6'h20;
  localparam logic [ADDR_W-1:0] OFS_IER  = 6'h24;
  localparam logic [ADDR_W-1:0] OFS_IPR  = 6'h28;
  localparam logic [ADDR_W-1:0] OFS_CTL  = 6'h2C;

  // interrupt source bit positions
  localparam int IRQ_TXTH = 0;
  localparam int IRQ_RXTH = 1;
  localparam int IRQ_ERR  = 2;
  localparam int NUM_IRQ  = 3;

  // status word, LSB is last field
  typedef struct packed {
    logic rx_thr;
    logic tx_thr;
    logic tx_full;
    logic rx_empty;
  } mbx_status_t;

  // error word
  typedef struct packed {
    logic full_wr;
    logic empty_rd;
  } mbx_err_t;

endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);

  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             push_ok, pop_ok, mem_we;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == FULL_CNT);
  assign empty   = (cnt_q == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign mem_we  = push_ok && !clr;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (clr) begin
      wptr_d = '0;
      rptr_d = '0;
      cnt_d  = '0;
    end else begin
      if (push_ok) wptr_d = bump(wptr_q);
      if (pop_ok)  rptr_d = bump(rptr_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  // storage carries no reset; written only under its enable
  always_ff @(posedge clk) begin
    if (mem_we) mem[wptr_q] <= wdata;
  end

  assign rdata = mem[rptr_q];
  assign count = cnt_q;

endmodule

// File: rtl/mbx_irq.sv
module mbx_irq #(
  parameter int N = 3,
  parameter logic [N-1:0] SRC_RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src,
  input  logic         w1c_en,
  input  logic [N-1:0] w1c_mask,
  input  logic         ie_we,
  input  logic [N-1:0] ie_wdata,
  output logic [N-1:0] is_o,
  output logic [N-1:0] ie_o,
  output logic [N-1:0] ip_o,
  output logic         irq_o
);

  logic [N-1:0] prev_q, is_q, is_d, ie_q, ie_d;

  for (genvar i = 0; i < N; i++) begin : g_bit
    // set on a rising source edge wins over a same-cycle clear
    always_comb begin
      is_d[i] = is_q[i];
      if (w1c_en && w1c_mask[i]) is_d[i] = 1'b0;
      if (src[i] && !prev_q[i])  is_d[i] = 1'b1;
    end
  end

  always_comb begin
    ie_d = ie_q;
    if (ie_we) ie_d = ie_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= SRC_RST;
      is_q   <= '0;
      ie_q   <= '0;
    end else begin
      prev_q <= src;
      is_q   <= is_d;
      ie_q   <= ie_d;
    end
  end

  assign is_o  = is_q;
  assign ie_o  = ie_q;
  assign ip_o  = is_q & ie_q;
  assign irq_o = |ip_o;

endmodule

// File: rtl/mbx_endpoint.sv
module mbx_endpoint
  import mbx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data
  ,output logic             irq
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_sync = rst_sync_q[1];

  // register decode
  logic wr_txd, wr_ctl, wr_txth, wr_rxth, wr_isr, wr_ier;
  logic rd_rxd, rd_err;

  assign wr_txd  = reg_wr_en && (reg_addr == OFS_TXD);
  assign wr_ctl  = reg_wr_en && (reg_addr == OFS_CTL);
  assign wr_txth = reg_wr_en && (reg_addr == OFS_TXTH);
  assign wr_rxth = reg_wr_en && (reg_addr == OFS_RXTH);
  assign wr_isr  = reg_wr_en && (reg_addr == OFS_ISR);
  assign wr_ier  = reg_wr_en && (reg_addr == OFS_IER);
  assign rd_rxd  = reg_rd_en && (reg_addr == OFS_RXD);
  assign rd_err  = reg_rd_en && (reg_addr == OFS_ERR);

  // FIFOs (R2, R3, R10)
  logic             snd_clr, rcv_clr, snd_full, snd_empty, rcv_full, rcv_empty;
  logic             snd_pop, rcv_push;
  logic [CNT_W-1:0] snd_cnt, rcv_cnt;
  logic [DATA_W-1:0] rcv_head;

  assign snd_clr  = wr_ctl && reg_wdata[0];
  assign rcv_clr  = wr_ctl && reg_wdata[1];
  assign snd_pop  = tx_valid && tx_ready;
  assign rcv_push = rx_valid && rx_ready;

  mbx_fifo #(.DEPTH(DEPTH), .WIDTH(DATA_W)) u_snd_fifo (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .clr   (snd_clr),
    .push  (wr_txd),
    .pop   (snd_pop),
    .wdata (reg_wdata),
    .rdata (tx_data),
    .count (snd_cnt),
    .full  (snd_full),
    .empty (snd_empty)
  );

  mbx_fifo #(.DEPTH(DEPTH), .WIDTH(DATA_W)) u_rcv_fifo (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .clr   (rcv_clr),
    .push  (rcv_push),
    .pop   (rd_rxd),
    .wdata (rx_data),
    .rdata (rcv_head),
    .count (rcv_cnt),
    .full  (rcv_full),
    .empty (rcv_empty)
  );

  assign tx_valid = !snd_empty;
  assign rx_ready = !rcv_full;

  // error capture (R4, R5, R6)
  mbx_err_t err_q, err_d;
  logic     ev_full_wr, ev_empty_rd, err_evt;

  assign ev_full_wr  = wr_txd && snd_full;
  assign ev_empty_rd = rd_rxd && rcv_empty;
  assign err_evt     = ev_full_wr || ev_empty_rd;

  always_comb begin
    err_d = err_q;
    if (rd_err) err_d = '0;
    if (ev_full_wr)  err_d.full_wr  = 1'b1;
    if (ev_empty_rd) err_d.empty_rd = 1'b1;
  end

  // thresholds (R7, R8, R9)
  logic [CNT_W-1:0] txth_q, txth_d, rxth_q, rxth_d;
  logic             tx_thr, rx_thr;

  always_comb begin
    txth_d = txth_q;
    rxth_d = rxth_q;
    if (wr_txth) txth_d = reg_wdata[CNT_W-1:0];
    if (wr_rxth) rxth_d = reg_wdata[CNT_W-1:0];
  end

  assign tx_thr = (snd_cnt <= txth_q);
  assign rx_thr = (rcv_cnt > rxth_q);

  // interrupts (R11, R12); transmit flag is true out of reset
  logic [NUM_IRQ-1:0] irq_src, irq_is, irq_ie, irq_ip;

  always_comb begin
    irq_src = '0;
    irq_src[IRQ_TXTH] = tx_thr;
    irq_src[IRQ_RXTH] = rx_thr;
    irq_src[IRQ_ERR]  = err_evt;
  end

  mbx_irq #(.N(NUM_IRQ), .SRC_RST(NUM_IRQ'(1) << IRQ_TXTH)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .src      (irq_src),
    .w1c_en   (wr_isr),
    .w1c_mask (reg_wdata[NUM_IRQ-1:0]),
    .ie_we    (wr_ier),
    .ie_wdata (reg_wdata[NUM_IRQ-1:0]),
    .is_o     (irq_is),
    .ie_o     (irq_ie),
    .ip_o     (irq_ip),
    .irq_o    (irq)
  );

  // read path
  mbx_status_t       stat;
  logic [DATA_W-1:0] rdata_d, rdata_q;

  always_comb begin
    stat.rx_empty = rcv_empty;
    stat.tx_full  = snd_full;
    stat.tx_thr   = tx_thr;
    stat.rx_thr   = rx_thr;
  end

  always_comb begin
    rdata_d = rdata_q;
    if (reg_rd_en) begin
      case (reg_addr)
        OFS_RXD:  rdata_d = rcv_empty ? '0 : rcv_head;
        OFS_STAT: rdata_d = DATA_W'(stat);
        OFS_ERR:  rdata_d = DATA_W'(err_q);
        OFS_TXTH: rdata_d = DATA_W'(txth_q);
        OFS_RXTH: rdata_d = DATA_W'(rxth_q);
        OFS_ISR:  rdata_d = DATA_W'(irq_is);
        OFS_IER:  rdata_d = DATA_W'(irq_ie);
        OFS_IPR:  rdata_d = DATA_W'(irq_ip);
        default:  rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      err_q   <= '0;
      txth_q  <= '0;
      rxth_q  <= '0;
      rdata_q <= '0;
    end else begin
      err_q   <= err_d;
      txth_q  <= txth_d;
      rxth_q  <= rxth_d;
      rdata_q <= rdata_d;
    end
  end

  assign reg_rdata = rdata_q;

endmodule

// File: rtl/mbx_endpoint_chk.sv
module mbx_endpoint_chk
  import mbx_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr_en,
  input logic               reg_rd_en,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic               tx_valid,
  input logic               tx_ready,
  input logic [DATA_W-1:0]  tx_data,
  input logic               rx_valid,
  input logic               rx_ready,
  input logic               irq,
  input logic [CNT_W-1:0]   snd_cnt,
  input logic [CNT_W-1:0]   rcv_cnt,
  input logic               snd_clr,
  input logic [NUM_IRQ-1:0] irq_is,
  input logic [NUM_IRQ-1:0] irq_ie
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  assert_tx_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !snd_clr) |=> (tx_valid && $stable(tx_data)));

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (snd_cnt <= FULL_CNT) && (rcv_cnt <= FULL_CNT));

  assert_rx_backpressure_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rcv_cnt == FULL_CNT) |-> !rx_ready);

  assert_full_write_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == OFS_TXD && snd_cnt == FULL_CNT && !(tx_valid && tx_ready))
    |=> (snd_cnt == FULL_CNT));

  assert_empty_read_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_en && reg_addr == OFS_RXD && rcv_cnt == '0 && !(rx_valid && rx_ready))
    |=> (rcv_cnt == '0));

  assert_is_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(irq_is) & ~irq_is)) |-> $past(reg_wr_en && reg_addr == OFS_ISR));

  assert_irq_masked_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_is & irq_ie) == '0) |-> !irq);

  assert_irq_source_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_is != '0));

endmodule

bind mbx_endpoint mbx_endpoint_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_sync),
  .reg_wr_en (reg_wr_en),
  .reg_rd_en (reg_rd_en),
  .reg_addr  (reg_addr),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .tx_data   (tx_data),
  .rx_valid  (rx_valid),
  .rx_ready  (rx_ready),
  .irq       (irq),
  .snd_cnt   (snd_cnt),
  .rcv_cnt   (rcv_cnt),
  .snd_clr   (snd_clr),
  .irq_is    (irq_is),
  .irq_ie    (irq_ie)
);

// File: tb/mbx_endpoint_tb.sv
`timescale 1ns/1ps
module mbx_endpoint_tb;
  import mbx_pkg::*;

  localparam int DEPTH = 4;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr_en, reg_rd_en, tx_ready, rx_valid;
  logic [5:0]  reg_addr;
  logic [31:0] reg_wdata, rx_data;
  logic [31:0] reg_rdata, tx_data;
  logic        tx_valid, rx_ready, irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  mbx_endpoint #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .irq(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd_en = 1'b0;
    d = reg_rdata;
  endtask

  task automatic tx_take(output logic [31:0] d, output logic v);
    @(negedge clk);
    v = tx_valid; d = tx_data; tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  task automatic rx_push(logic [31:0] d, output logic r);
    @(negedge clk);
    r = rx_ready; rx_valid = 1'b1; rx_data = d;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic        f;
    reg_wr_en = 0; reg_rd_en = 0; tx_ready = 0; rx_valid = 0;
    reg_addr = '0; reg_wdata = '0; rx_data = '0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(OFS_STAT, d); check("R1 status", d, 32'h5);
    rd(OFS_ERR, d);  check("R1 error", d, 0);
    rd(OFS_TXTH, d); check("R1 tx threshold", d, 0);
    rd(OFS_RXTH, d); check("R1 rx threshold", d, 0);
    rd(OFS_ISR, d);  check("R1 int status", d, 0);
    rd(OFS_IER, d);  check("R1 int enable", d, 0);
    rd(OFS_IPR, d);  check("R1 int pending", d, 0);
    check("R1 irq", 32'(irq), 0);
    check("R1 tx_valid", 32'(tx_valid), 0);
    check("R1 rx_ready", 32'(rx_ready), 1);

    // R9 masking of thresholds
    wr(OFS_TXTH, 32'hFFFF_FFFF); rd(OFS_TXTH, d);
    check("R9 tx threshold mask", d, (32'd1 << CNT_W) - 1);
    wr(OFS_RXTH, 32'hFFFF_FFF2); rd(OFS_RXTH, d);
    check("R9 rx threshold mask", d, 32'hFFFF_FFF2 & ((32'd1 << CNT_W) - 1));

    // outbound sweep: every threshold against every occupancy
    for (int thr = 0; thr <= DEPTH; thr++) begin
      wr(OFS_TXTH, 32'(thr));
      for (int c = 0; c <= DEPTH; c++) begin
        rd(OFS_STAT, d);
        check("R7 tx threshold flag", 32'(d[2]), 32'(c <= thr));
        check("R2 tx full flag", 32'(d[1]), 32'(c == DEPTH));
        if (c < DEPTH) wr(OFS_TXD, 32'hA000_0000 + 32'(thr * 16 + c));
      end
      wr(OFS_TXD, 32'hDEAD_BEEF);
      rd(OFS_ERR, d); check("R4 full-write error bit", d, 32'h2);
      rd(OFS_ERR, d); check("R6 error cleared by read", d, 0);
      for (int c = 0; c < DEPTH; c++) begin
        tx_take(d, f);
        check("R2 tx_valid while queued", 32'(f), 1);
        check("R4 tx order, overflow dropped", d, 32'hA000_0000 + 32'(thr * 16 + c));
      end
      @(negedge clk);
      check("R2 tx_valid after drain", 32'(tx_valid), 0);
    end

    // inbound sweep
    for (int thr = 0; thr <= DEPTH; thr++) begin
      wr(OFS_RXTH, 32'(thr));
      for (int c = 0; c <= DEPTH; c++) begin
        rd(OFS_STAT, d);
        check("R8 rx threshold flag", 32'(d[3]), 32'(c > thr));
        check("R3 rx empty flag", 32'(d[0]), 32'(c == 0));
        if (c < DEPTH) begin
          rx_push(32'hB000_0000 + 32'(thr * 16 + c), f);
          check("R3 rx_ready below full", 32'(f), 1);
        end
      end
      rx_push(32'hCAFE_0000, f);
      check("R3 rx_ready at full", 32'(f), 0);
      for (int c = 0; c < DEPTH; c++) begin
        rd(OFS_RXD, d);
        check("R3 rx order", d, 32'hB000_0000 + 32'(thr * 16 + c));
      end
      rd(OFS_RXD, d); check("R5 empty read returns zero", d, 0);
      rd(OFS_STAT, d); check("R5 still empty", 32'(d[0]), 1);
      rd(OFS_ERR, d); check("R6 empty-read error bit", d, 32'h1);
      rd(OFS_ERR, d); check("R6 error cleared", d, 0);
    end
    rx_push(32'h1357_9BDF, f);
    rd(OFS_RXD, d); check("R5 fifo intact after empty read", d, 32'h1357_9BDF);

    // R10 flushes
    wr(OFS_TXTH, 0);
    wr(OFS_TXD, 32'h11); wr(OFS_TXD, 32'h22); wr(OFS_TXD, 32'h33);
    rx_push(32'h44, f); rx_push(32'h55, f);
    wr(OFS_CTL, 32'h1);
    @(negedge clk);
    check("R10 tx flushed", 32'(tx_valid), 0);
    rd(OFS_STAT, d); check("R10 rx untouched by tx flush", 32'(d[0]), 0);
    wr(OFS_CTL, 32'h2);
    rd(OFS_STAT, d); check("R10 rx flushed", 32'(d[0]), 1);
    rd(OFS_CTL, d);  check("R10 control reads zero", d, 0);
    wr(OFS_TXD, 32'h66);
    tx_take(d, f);   check("R10 tx usable after flush", d, 32'h66);

    // R11 / R12 interrupts
    wr(OFS_RXTH, 0); wr(OFS_IER, 0); wr(OFS_ISR, 32'h7);
    rd(OFS_ISR, d);  check("R11 status cleared", d, 0);
    rx_push(32'h77, f);
    rd(OFS_ISR, d);  check("R11 rx threshold edge", d, 32'h2);
    rd(OFS_IPR, d);  check("R12 pending masked", d, 0);
    check("R12 irq masked", 32'(irq), 0);
    wr(OFS_IER, 32'h4);
    check("R12 irq other enable", 32'(irq), 0);
    wr(OFS_IER, 32'h2);
    check("R12 irq enabled", 32'(irq), 1);
    rd(OFS_IPR, d);  check("R12 pending value", d, 32'h2);
    wr(OFS_ISR, 32'h1);
    rd(OFS_ISR, d);  check("R11 sticky under other clear", d, 32'h2);
    wr(OFS_ISR, 32'h2);
    rd(OFS_ISR, d);  check("R11 write-one clears", d, 0);
    check("R12 irq after clear", 32'(irq), 0);
    wr(OFS_IER, 32'h4);
    rd(OFS_RXD, d);  check("R3 pop before error", d, 32'h77);
    rd(OFS_RXD, d);
    rd(OFS_ISR, d);  check("R11 error event", d, 32'h4);
    check("R12 irq on error", 32'(irq), 1);
    wr(OFS_TXD, 32'h88);
    tx_take(d, f);
    rd(OFS_ISR, d);  check("R11 tx threshold edge", d, 32'h5);
    wr(OFS_ISR, 32'h7);
    rd(OFS_ISR, d);  check("R11 clear all", d, 0);
    check("R12 irq idle", 32'(irq), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule